// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Image Checksum

This block reads 16-bit words from a three-wire serial EEPROM of the 93C family. It drives the chip select, the serial clock and the command line, and it samples the data line coming back from the device. Every access is one full read frame: chip select goes high, then the block sends a start bit, the read opcode and the word address, the device returns a dummy bit and then the word, and chip select drops again for a guaranteed minimum time.

There are two operating modes, and the `scan` input picks one when `start` is accepted. A single read fetches the word at `addr` and presents it on `rd_word` with a one-cycle `data_valid` strobe. A scan reads every word in the device from address zero upward and keeps a 16-bit running sum. When it finishes it pulses `done`, and `checksum_ok` then shows whether that sum came to zero. The parameter `LARGE` selects the device size (256 or 1024 words). `HALF_DIV` sets the length of each serial clock phase in system clocks, and `CS_GAP` sets the minimum chip-select-low time.

Top module: `mw_eeprom_rd`

## Requirements
- R1: After reset `mw_cs`, `mw_sk`, `mw_mosi`, `busy`, `data_valid`, `done` and `checksum_ok` are all low.
- R2: Each frame's header is a start bit of 1, then opcode bits 1 then 0, then the word address, all sent most significant bit first. The address is 8 bits when `LARGE`=0 (256 words) and 10 bits when `LARGE`=1 (1024 words).
- R3: After the header, the data line gives one dummy bit and then 16 data bits, most significant first. In a single read, `rd_word` takes the value of the addressed word, and `data_valid` is high for exactly one cycle, on the first cycle after the frame's last bit is sampled.
- R4: `mw_mosi` changes only while `mw_sk` is low. It never changes between two consecutive cycles in which `mw_sk` is high.
- R5: `mw_sk` is low whenever `mw_cs` is low, and `mw_cs` is high only while `busy` is high.
- R6: A single read holds `busy` high for exactly NB*2*HALF_DIV + CS_GAP cycles, where NB = address bits + 20. A scan holds it for the number of words times that figure. Between frames, `mw_cs` stays low for at least CS_GAP cycles.
- R7: A scan reads addresses 0, 1, 2 and so on up to the last word, in that order, one frame each. It pulses `done` for one cycle after the last word, and it never raises `data_valid`.
- R8: After a scan, `checksum_ok` is 1 exactly when the sum of all words, taken modulo 2^16, is zero. It is cleared when a scan is accepted.
- R9: A `start` pulse while `busy` is high has no effect. The running frame keeps its address, its mode and its timing.
- R10: Each serial clock phase, high and low, lasts HALF_DIV system clocks. The data line is sampled as the clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when idle |
| scan | input | 1 | 1: whole-device checksum scan, 0: single read |
| addr | input | AW (8 or 10) | Word address for a single read |
| busy | output | 1 | Operation in progress, including the trailing chip-select gap |
| data_valid | output | 1 | One-cycle strobe: `rd_word` holds a fresh word |
| rd_word | output | 16 | Word returned by the last single read |
| done | output | 1 | One-cycle strobe at the end of a scan |
| checksum_ok | output | 1 | Result of the last completed scan |
| mw_cs | output | 1 | EEPROM chip select |
| mw_sk | output | 1 | EEPROM serial clock |
| mw_mosi | output | 1 | Command and address line to the EEPROM |
| mw_miso | input | 1 | Data line from the EEPROM |

## Verification
The hardest case to reach is a `start` request that arrives in the middle of a frame. The bench issues a second request with a different address, and with the scan mode set, part way through a single read. The EEPROM model must then still decode only the first address, and the busy timeline must not stretch. The checksum path needs a full image that sums to exactly zero, so the bench fills the device with an uneven pattern, places a signature word at 0x7F and solves the last word so the total cancels. It then flips one bit of one word and scans again.

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
  parameter int LARGE    = 0,
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 3,
  localparam int AW      = (LARGE != 0) ? 10 : 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          scan,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          data_valid,
  output logic [15:0]   rd_word,
  output logic          done,
  output logic          checksum_ok,
  output logic          mw_cs,
  output logic          mw_sk,
  output logic          mw_mosi,
  input  logic          mw_miso
);
  localparam int WORDS = 1 << AW;
  localparam int CW    = 3 + AW;
  localparam int NB    = CW + 17;
  localparam int BW    = $clog2(NB + 1);
  localparam int DW    = $clog2(HALF_DIV + 1);
  localparam int GW    = $clog2(CS_GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t           st;
  logic          phase, scan_m;
  logic [DW-1:0] divcnt;
  logic [BW-1:0] bitcnt;
  logic [GW-1:0] gcnt;
  logic [CW-1:0] txsh;
  logic [14:0]   rx;
  logic [AW-1:0] cur;
  logic [15:0]   sum;

  wire [15:0] word_nx = {rx, mw_miso};
  wire [15:0] sum_nx  = sum + word_nx;
  wire        tick    = (divcnt == DW'(HALF_DIV - 1));
  wire        last_b  = (bitcnt == BW'(NB - 1));
  wire        last_w  = (cur == AW'(WORDS - 1));

  assign busy    = (st != S_IDLE);
  assign mw_cs   = (st == S_RUN);
  assign mw_sk   = mw_cs & phase;
  assign mw_mosi = mw_cs & txsh[CW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      phase       <= 1'b0;
      scan_m      <= 1'b0;
      divcnt      <= '0;
      bitcnt      <= '0;
      gcnt        <= '0;
      txsh        <= '0;
      rx          <= '0;
      cur         <= '0;
      sum         <= '0;
      rd_word     <= '0;
      data_valid  <= 1'b0;
      done        <= 1'b0;
      checksum_ok <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      done       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          scan_m <= scan;
          cur    <= scan ? '0 : addr;
          txsh   <= {3'b110, (scan ? {AW{1'b0}} : addr)};
          if (scan) begin
            sum         <= '0;
            checksum_ok <= 1'b0;
          end
          phase  <= 1'b0;
          divcnt <= '0;
          bitcnt <= '0;
          st     <= S_RUN;
        end
        S_RUN: begin
          if (!tick) divcnt <= divcnt + 1'b1;
          else begin
            divcnt <= '0;
            phase  <= ~phase;
            if (phase) begin
              rx     <= word_nx[14:0];
              txsh   <= {txsh[CW-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
              if (last_b) begin
                st   <= S_GAP;
                gcnt <= '0;
                if (!scan_m) begin
                  rd_word    <= word_nx;
                  data_valid <= 1'b1;
                end else begin
                  sum <= sum_nx;
                  if (last_w) begin
                    done        <= 1'b1;
                    checksum_ok <= (sum_nx == 16'h0);
                  end
                end
              end
            end
          end
        end
        S_GAP: begin
          if (gcnt != GW'(CS_GAP - 1)) gcnt <= gcnt + 1'b1;
          else if (scan_m && !last_w) begin
            cur    <= cur + 1'b1;
            txsh   <= {3'b110, cur + 1'b1};
            phase  <= 1'b0;
            divcnt <= '0;
            bitcnt <= '0;
            st     <= S_RUN;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_rd_chk.sv
module mw_eeprom_rd_chk #(
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 3
) (
  input logic clk,
  input logic rst_n,
  input logic mw_cs,
  input logic mw_sk,
  input logic mw_mosi,
  input logic busy,
  input logic data_valid,
  input logic done
);
  int hicnt;
  int lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hicnt  <= 0;
      lowcnt <= CS_GAP;
    end else begin
      hicnt <= mw_sk ? hicnt + 1 : 0;
      if (mw_cs) lowcnt <= 0;
      else if (lowcnt < CS_GAP) lowcnt <= lowcnt + 1;
    end
  end

  p_sk_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n) !mw_cs |-> !mw_sk);
  p_cs_busy_r5:  assert property (@(posedge clk) disable iff (!rst_n) mw_cs |-> busy);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_mosi));
  p_dv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) data_valid |=> !data_valid);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_dv_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n) !(data_valid && done));
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n) $rose(mw_cs) |-> lowcnt >= CS_GAP);
  p_hi_len_r10: assert property (@(posedge clk) disable iff (!rst_n) $fell(mw_sk) |-> hicnt == HALF_DIV);
endmodule

bind mw_eeprom_rd mw_eeprom_rd_chk #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_mosi(mw_mosi),
  .busy(busy), .data_valid(data_valid), .done(done)
);

// File: tb/test_mw_eeprom_rd.sv
`timescale 1ns/1ps
module test_mw_eeprom_rd;
  localparam int HD = 2, GP = 3, AW = 8, W = 256;
  localparam int CW = 3 + AW, NB = CW + 17, TW = NB * 2 * HD + GP;

  logic clk = 0, rst_n = 0, start = 0, scan = 0, miso = 0;
  logic [AW-1:0] addr = '0;
  logic busy, data_valid, done, checksum_ok, mw_cs, mw_sk, mw_mosi;
  logic [15:0] rd_word;

  always #2.5 clk = ~clk;

  mw_eeprom_rd #(.LARGE(0), .HALF_DIV(HD), .CS_GAP(GP)) i_mw_eeprom_rd (
    .clk(clk), .rst_n(rst_n), .start(start), .scan(scan), .addr(addr),
    .busy(busy), .data_valid(data_valid), .rd_word(rd_word), .done(done),
    .checksum_ok(checksum_ok), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_mosi(mw_mosi),
    .mw_miso(miso)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] mem [W];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] img_sum();
    logic [15:0] s = 0;
    for (int i = 0; i < W; i++) s += mem[i];
    return s;
  endfunction

  // behavioural reference of the operation timeline
  int left = 0, frames = 0;
  bit m_scan = 0, exp_ok = 0;
  logic [AW-1:0] m_addr = 0;
  always @(posedge clk) begin
    if (!rst_n) left = 0;
    else if (left == 0 && start) begin
      left = scan ? W * TW : TW;
      m_scan = scan; m_addr = addr; frames = 0;
      if (scan) exp_ok = 0;
    end else if (left > 0) begin
      left--;
      if (left == GP && m_scan) exp_ok = (img_sum() == 16'h0);
    end
  end

  // EEPROM model
  int k = 0;
  logic [CW-1:0] fr;
  always @(posedge mw_cs) k = 0;
  always @(posedge mw_sk) if (mw_cs) begin
    if (k < CW) begin
      fr = {fr[CW-2:0], mw_mosi};
      if (k == CW - 1) begin
        chk(fr[CW-1] == 1'b1, "R2 start bit", fr[CW-1], 1);
        chk(fr[CW-2:CW-3] == 2'b10, "R2 opcode", fr[CW-2:CW-3], 2);
        chk(fr[AW-1:0] == (m_scan ? AW'(frames) : m_addr), "R2/R7 address",
            fr[AW-1:0], m_scan ? frames : m_addr);
        frames++;
      end
    end else if (k == CW) miso = 1'b0;
    else if (k <= CW + 16) miso = mem[fr[AW-1:0]][15 - (k - CW - 1)];
    k++;
  end

  // per-clock comparison
  logic p_sk = 0, p_mosi = 0, p_cs = 0;
  int hic = 0, lowc = GP;
  always @(negedge clk) if (rst_n && !finished) begin
    chk(busy == (left > 0), "R6 busy", busy, left > 0);
    chk(data_valid == (left == GP && !m_scan), "R3 data_valid", data_valid, left == GP && !m_scan);
    chk(done == (left == GP && m_scan), "R7 done", done, left == GP && m_scan);
    chk(checksum_ok == exp_ok, "R8 checksum_ok", checksum_ok, exp_ok);
    if (data_valid) chk(rd_word == mem[m_addr], "R3 rd_word", rd_word, mem[m_addr]);
    if (p_sk && mw_sk) chk(mw_mosi == p_mosi, "R4 mosi hold", mw_mosi, p_mosi);
    if (!mw_cs) chk(!mw_sk, "R5 sk outside cs", mw_sk, 0);
    if (mw_cs) chk(busy, "R5 cs while idle", busy, 1);
    if (mw_cs && !p_cs) chk(lowc >= GP, "R6 cs gap", lowc, GP);
    if (p_sk && !mw_sk) chk(hic == HD, "R10 high phase", hic, HD);
    hic  = mw_sk ? hic + 1 : 0;
    lowc = mw_cs ? 0 : lowc + 1;
    p_sk = mw_sk; p_mosi = mw_mosi; p_cs = mw_cs;
  end

  task automatic op(input bit sc, input logic [AW-1:0] a);
    @(negedge clk); scan = sc; addr = a; start = 1;
    @(negedge clk); start = 0; scan = 0;
    repeat ((sc ? W * TW : TW) + 2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < W; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    mem[8'h7F] = 16'h9356;
    mem[W-1] = 0;
    mem[W-1] = -img_sum();
    repeat (4) @(negedge clk);
    chk({mw_cs, mw_sk, mw_mosi, busy, data_valid, done, checksum_ok} == 7'b0, "R1 reset",
        {mw_cs, mw_sk, mw_mosi, busy, data_valid, done, checksum_ok}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({mw_cs, mw_sk, busy} == 3'b0, "R1 after reset", {mw_cs, mw_sk, busy}, 0);
    op(0, 8'h7F); chk(rd_word == 16'h9356, "R3 signature word", rd_word, 16'h9356);
    op(0, 8'h00); chk(rd_word == mem[0], "R3 addr 0", rd_word, mem[0]);
    op(0, 8'hFF); chk(rd_word == mem[255], "R3 last addr", rd_word, mem[255]);
    op(0, 8'hAA); chk(rd_word == mem[8'hAA], "R3 addr AA", rd_word, mem[8'hAA]);
    // R9: request during a running read
    @(negedge clk); addr = 8'h11; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    addr = 8'h22; scan = 1; start = 1;
    @(negedge clk); start = 0; scan = 0;
    repeat (TW) @(negedge clk);
    chk(frames == 1, "R9 single frame", frames, 1);
    chk(rd_word == mem[8'h11], "R9 address kept", rd_word, mem[8'h11]);
    chk(!busy, "R9 timing kept", busy, 0);
    op(1, 0);
    chk(frames == W, "R7 frame count", frames, W);
    chk(checksum_ok == 1'b1, "R8 good image", checksum_ok, 1);
    mem[3] = mem[3] ^ 16'h0001;
    @(negedge clk); scan = 1; start = 1;
    @(negedge clk); start = 0; scan = 0;
    chk(checksum_ok == 1'b0, "R8 cleared at scan start", checksum_ok, 0);
    repeat (W * TW + 2) @(negedge clk);
    chk(checksum_ok == 1'b0, "R8 bad image", checksum_ok, 0);
    op(0, 8'h03); chk(rd_word == mem[3], "R3 after scan", rd_word, mem[3]);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule